// File: doc/BRIEF.md
# Reloading Down-Counting Interval Timer

A single timer channel that divides a count-clock enable into a periodic interrupt. Software, or a neighbouring block, sets a reload value and issues a one-cycle start strobe. The channel then waits for the next count-clock tick. That tick is the start trigger: it loads the reload value into the counter and, if asked to, raises an interrupt. From then on the counter steps down once per tick. When a tick finds the counter at zero, the channel pulses the interrupt, reloads and keeps running.

The count-clock enable comes from an external prescaler. It is one system-clock cycle wide, as are the start trigger and the interrupt. Because start waits for a tick, the first period can run up to one count clock longer than the later ones. Setting the start-interrupt bit gives an exact timing reference for the start. A stop strobe freezes the channel. A second start while running re-arms it.

Top module: `interval_timer`

## Requirements
- R1: While rst_ni is low, count_o is all ones (0xFFFF at the default width), en_o is 0 and irq_o is 0.
- R2: A start strobe sets en_o in the next cycle. The counter then holds its value until the first tick that is not in a start or stop cycle.
- R3: The first such tick after a start is the start trigger. It loads reload_i into the counter, visible in the next cycle.
- R4: If start_irq_i is 1 at the start trigger, irq_o is 1 in the next cycle. If it is 0, irq_o stays 0 for the trigger.
- R5: While running, a tick with a nonzero counter decrements it by exactly one.
- R6: While running, a tick with the counter at zero makes irq_o 1 in the next cycle and reloads reload_i. The channel keeps running, so consecutive terminal interrupts are reload_i+1 ticks apart.
- R7: A stop strobe clears en_o in the next cycle. The counter then keeps its value and no interrupt occurs until the next start. Stop wins over a start in the same cycle.
- R8: A start while en_o is 1 re-arms the channel. A tick in the cycle of the start strobe is ignored, and the next tick is again a start trigger that reloads.
- R9: irq_o is only ever 1 in the cycle after a cycle with tick_i high. Each interrupt event gives exactly one cycle of irq_o.
- R10: reload_i is sampled at the moment of each load, so a change takes effect at the next trigger or terminal reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count-clock enable |
| start_i | input | 1 | Start / restart strobe |
| stop_i | input | 1 | Stop strobe |
| start_irq_i | input | 1 | Raise the interrupt on the start trigger |
| reload_i | input | WIDTH | Reload value |
| count_o | output | WIDTH | Current counter value |
| en_o | output | 1 | Channel enabled |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench uses the default WIDTH of 16, so the reset value 0xFFFF is checked exactly. It uses small reload values (0, 2, 3, 4) so that many full periods fit into a short run. The tick divider in the bench switches between one tick every five cycles and one tick every cycle. The slow rate exposes the hold phase between start and trigger. The fast rate makes ticks land in the same cycle as start strobes and gives back-to-back interrupts with a reload value of zero.

// File: rtl/it_pkg.sv
package it_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } it_state_e;
endpackage

// File: rtl/it_ctrl.sv
module it_ctrl
  import it_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      start_i,
  input  logic      stop_i,
  output it_state_e state_o,
  output logic      trig_o,
  output logic      step_o
);
  it_state_e state_q;
  logic      quiet;

  // a cycle carrying a start or stop strobe never counts
  assign quiet   = tick_i & ~start_i & ~stop_i;
  assign trig_o  = quiet & (state_q == ST_ARMED);
  assign step_o  = quiet & (state_q == ST_RUN);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_IDLE;
    else if (stop_i)  state_q <= ST_IDLE;
    else if (start_i) state_q <= ST_ARMED;
    else if (trig_o)  state_q <= ST_RUN;
  end
endmodule

// File: rtl/it_count.sv
module it_count #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] cnt_q;

  assign tc_o    = step_i & (cnt_q == '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (trig_i || tc_o)  cnt_q <= reload_i;
    else if (step_i)          cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/it_irq.sv
module it_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic tc_i,
  input  logic start_irq_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (trig_i & start_irq_i) | tc_i;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import it_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             start_irq_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] count_o,
  output logic             en_o,
  output logic             irq_o
);
  it_state_e state;
  logic      trig;
  logic      step;
  logic      tc;

  it_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .state_o (state),
    .trig_o  (trig),
    .step_o  (step)
  );

  it_count #(.WIDTH(WIDTH)) i_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .step_i   (step),
    .reload_i (reload_i),
    .count_o  (count_o),
    .tc_o     (tc)
  );

  it_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .tc_i        (tc),
    .start_irq_i (start_irq_i),
    .irq_o       (irq_o)
  );

  assign en_o = (state != ST_IDLE);
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import it_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             start_irq_i,
  input logic [WIDTH-1:0] reload_i,
  input logic [WIDTH-1:0] count_o,
  input logic             en_o,
  input logic             irq_o,
  input it_state_e        state
);
  logic armed_tick, run_tick;
  assign armed_tick = (state == ST_ARMED) && tick_i && !start_i && !stop_i;
  assign run_tick   = (state == ST_RUN)   && tick_i && !start_i && !stop_i;

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !irq_o && !en_o);

  p_start_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> en_o);

  p_armed_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ARMED) && !tick_i |=> $stable(count_o));

  p_trig_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_tick |=> count_o == $past(reload_i));

  p_trig_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_tick |=> irq_o == $past(start_irq_i));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_tick && count_o != '0 |=> count_o == WIDTH'($past(count_o) - 1'b1));

  p_terminal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_tick && count_o == '0 |=> irq_o && count_o == $past(reload_i));

  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !en_o && !irq_o);

  p_idle_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(count_o) && !irq_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> (state == ST_ARMED) && $stable(count_o));

  p_irq_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));
endmodule

bind interval_timer interval_timer_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_irq_i (start_irq_i),
  .reload_i    (reload_i),
  .count_o     (count_o),
  .en_o        (en_o),
  .irq_o       (irq_o),
  .state       (state)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         start_i = 1'b0;
  logic         stop_i = 1'b0;
  logic         start_irq_i = 1'b0;
  logic [W-1:0] reload_i = '0;
  logic [W-1:0] count_o;
  logic         en_o;
  logic         irq_o;

  always #4 clk_i = ~clk_i;

  interval_timer #(.WIDTH(W)) i_interval_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .stop_i(stop_i), .start_irq_i(start_irq_i), .reload_i(reload_i),
    .count_o(count_o), .en_o(en_o), .irq_o(irq_o)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    exp_q[$];
  string cur = "R1";
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // tick generator: one tick every tdiv cycles, none when tdiv is 0
  int tdiv = 0;
  int tph = 0;
  always @(negedge clk_i) begin
    if (tdiv == 0) tick_i = 1'b0;
    else begin
      tph = (tph + 1) % tdiv;
      tick_i = (tph == 0);
    end
  end

  // reference model built from the requirements; pushes expected irq cycles
  logic [W-1:0] m_cnt = '1;
  bit           m_en = 1'b0;
  bit           m_pend = 1'b0;
  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_cnt = '1; m_en = 0; m_pend = 0;
    end else if (stop_i) begin
      m_en = 0; m_pend = 0;
    end else if (start_i) begin
      m_en = 1; m_pend = 1;
    end else if (m_en && tick_i) begin
      if (m_pend) begin
        m_cnt = reload_i; m_pend = 0;
        if (start_irq_i) exp_q.push_back(cyc);
      end else if (m_cnt == '0) begin
        m_cnt = reload_i;
        exp_q.push_back(cyc);
      end else begin
        m_cnt = m_cnt - 1'b1;
      end
    end
  end

  // monitor: compares outputs with the model and pops the irq scoreboard
  always @(negedge clk_i) begin
    if (mon_on && rst_ni) begin
      chk(count_o == m_cnt, "R3 R5 R10", {cur, " count"}, count_o, m_cnt);
      chk(en_o == m_en, "R2 R7", {cur, " en"}, en_o, m_en);
      if (irq_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", {cur, " unexpected irq"}, 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(e == cyc, "R4 R6 R9", {cur, " irq cycle"}, cyc, e);
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
        int e;
        e = exp_q.pop_front();
        chk(1'b0, "R4 R6", {cur, " missed irq"}, cyc, e);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] c0;
    wait_cyc(3);
    cur = "R1";
    chk(count_o == 16'hFFFF, "R1", "reset count", count_o, 16'hFFFF);
    chk(en_o == 1'b0, "R1", "reset en", en_o, 0);
    chk(irq_o == 1'b0, "R1", "reset irq", irq_o, 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;

    // R2: slow ticks expose the hold phase before the trigger
    cur = "R2";
    tdiv = 5; reload_i = 16'd3; start_irq_i = 1'b1;
    wait_cyc(1);
    pulse_start();
    chk(en_o == 1'b1, "R2", "en after start", en_o, 1);
    cur = "R6";
    wait_cyc(60);

    cur = "R10";
    reload_i = 16'd2;
    wait_cyc(40);

    cur = "R7";
    pulse_stop();
    chk(en_o == 1'b0, "R7", "en after stop", en_o, 0);
    c0 = count_o;
    wait_cyc(25);
    chk(count_o == c0, "R7", "frozen count", count_o, c0);
    @(negedge clk_i); start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; stop_i = 1'b0;
    chk(en_o == 1'b0, "R7", "stop beats start", en_o, 0);
    wait_cyc(10);

    cur = "R4";
    start_irq_i = 1'b0; reload_i = 16'd4;
    pulse_start();
    wait_cyc(50);

    // R8: ticks every cycle so restarts coincide with ticks
    cur = "R8";
    tdiv = 1; start_irq_i = 1'b1; reload_i = 16'd3;
    wait_cyc(7);
    pulse_start();
    wait_cyc(3);
    pulse_start();
    wait_cyc(20);

    cur = "R6";
    reload_i = 16'd0;
    pulse_start();
    wait_cyc(12);

    cur = "R7";
    pulse_stop();
    wait_cyc(6);
    chk(exp_q.size() == 0, "R6", "pending expected irqs", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule